// File: doc/BRIEF.md
# I2C Register Slave with Palette and Cursor Ports

This block is the host-facing front end of a video encoder's configuration space. An I2C master reaches three kinds of storage through it. The first is a flat set of 8-bit control registers. The second is a 256-entry colour look-up table, kept as three 8-bit banks that hold red, green and blue. The third is a 256-byte cursor bit map. SCL and SDA are brought into the system clock domain through short synchronisers. The block drives SDA only as an open-drain pull-down.

In a write transfer, the first data byte picks a register subaddress. Each later byte goes to the next subaddress. Two reserved subaddresses switch the transfer into memory mode instead. In that mode the next byte becomes a table index, and the bytes after it stream into the palette or the cursor memory, with the index advancing on its own. A read transfer returns register contents, starting at the current subaddress. The memories are written through strobed ports, and those strobes are held off while the digital power-down input is high.

Top module: `vreg_i2c_port`

## Requirements
- R1: The block acknowledges only the 7-bit device address 0x44 (address byte 0x88 for a write, 0x89 for a read). For any other address it does not pull SDA low and the remaining bytes of that transfer cause no strobe.
- R2: In a write, the first data byte sets the subaddress. Each later byte is written to the register at the subaddress, through a one-cycle `reg_we` pulse, and the subaddress then increases by one. Every data byte is acknowledged.
- R3: A read returns the register at the current subaddress, MSB first. The subaddress increases by one after each byte sent. A master NACK followed by STOP ends the read.
- R4: Writes aimed at the two status subaddresses (0x00 and 0x01 by default) raise no `reg_we`, and the subaddress still advances past them.
- R5: After subaddress 0xFF, the next byte is the palette index. The bytes after it are written as red, green and blue, through `lut_we` bit 0, 1 and 2 in that order, at that index. Only one bank strobe is high at a time.
- R6: The palette index increases by one after each complete red-green-blue triplet, and wraps from 255 to 0.
- R7: The colour phase returns to red on every START and on every new index byte, so a partial triplet does not shift the next entry.
- R8: After subaddress 0xFE, the next byte is the cursor index. Each byte after it is written through `cur_we` to one cursor entry, and the index increases by one per byte, wrapping from 255 to 0.
- R9: While `mem_pd` is high, no `lut_we` or `cur_we` strobe is raised. Bytes are still acknowledged, and register writes still take effect.
- R10: After reset, SDA is released and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low |
| mem_pd | input | 1 | Digital power-down, blocks memory strobes |
| reg_addr | output | 8 | Register subaddress |
| reg_we | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register contents at `reg_addr` |
| lut_we | output | NBANK | Per-colour palette bank write strobes |
| lut_addr | output | 8 | Palette index |
| lut_wdata | output | 8 | Palette byte |
| cur_we | output | 1 | Cursor write strobe |
| cur_addr | output | 8 | Cursor index |
| cur_wdata | output | 8 | Cursor byte |

## Verification
The bench builds the block with its default parameters: device address 0x44, status bytes at 0x00 and 0x01, palette and cursor entry points at 0xFF and 0xFE, three colour banks and two synchroniser stages. With 8-bit indices, the wrap from entry 255 to entry 0 takes only a few bytes, for both the palette and the cursor. The bench models the register file and both memories behind the ports, so the effect of each transfer can be read back over the bus or checked against the recorded strobes.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
  typedef enum logic [2:0] {
    B_IDLE, B_ADDR, B_AACK, B_WR, B_WACK, B_RD, B_RACK
  } bstate_t;

  typedef enum logic [2:0] {
    M_SUB, M_REG, M_LIDX, M_LDAT, M_CIDX, M_CDAT
  } wmode_t;
endpackage

// File: rtl/vreg_line_sync.sv
module vreg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // SDA edges while SCL stays high mark bus conditions
  assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/vreg_byte_engine.sv
module vreg_byte_engine
  import vreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_p,
  input  logic       stop_p,
  input  logic [7:0] tx_data,
  output logic       sda_oe,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       wr_begin,
  output logic       rd_next
);
  bstate_t    st;
  logic [3:0] bcnt;
  logic [7:0] sr, tx;
  logic       rw, more, ack_drv, dat_drv;

  assign sda_oe = ack_drv | (dat_drv & ~tx[7]);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= B_IDLE; bcnt <= '0; sr <= '0; tx <= '0; rw <= 1'b0;
      more <= 1'b0; ack_drv <= 1'b0; dat_drv <= 1'b0; rx_byte <= '0;
      rx_valid <= 1'b0; wr_begin <= 1'b0; rd_next <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      wr_begin <= 1'b0;
      rd_next  <= 1'b0;
      if (start_p) begin
        st <= B_ADDR; bcnt <= '0; ack_drv <= 1'b0; dat_drv <= 1'b0;
      end else if (stop_p) begin
        st <= B_IDLE; ack_drv <= 1'b0; dat_drv <= 1'b0;
      end else begin
        case (st)
          B_ADDR: begin
            if (scl_rise) begin
              sr <= {sr[6:0], sda_s}; bcnt <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == 4'd8) begin
              if (sr[7:1] == DEV_ADDR) begin
                ack_drv <= 1'b1; rw <= sr[0]; st <= B_AACK;
                wr_begin <= ~sr[0];
              end else begin
                st <= B_IDLE;
              end
            end
          end
          B_AACK: if (scl_fall) begin
            ack_drv <= 1'b0; bcnt <= '0;
            if (rw) begin
              tx <= tx_data; dat_drv <= 1'b1; st <= B_RD;
            end else begin
              st <= B_WR;
            end
          end
          B_WR: begin
            if (scl_rise) begin
              sr <= {sr[6:0], sda_s}; bcnt <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == 4'd8) begin
              ack_drv <= 1'b1; rx_byte <= sr; rx_valid <= 1'b1; st <= B_WACK;
            end
          end
          B_WACK: if (scl_fall) begin
            ack_drv <= 1'b0; bcnt <= '0; st <= B_WR;
          end
          B_RD: begin
            if (scl_rise) begin
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall) begin
              if (bcnt == 4'd8) begin
                dat_drv <= 1'b0; rd_next <= 1'b1; st <= B_RACK;
              end else begin
                tx <= {tx[6:0], 1'b0};
              end
            end
          end
          B_RACK: begin
            if (scl_rise) begin
              more <= ~sda_s;
            end else if (scl_fall) begin
              if (more) begin
                tx <= tx_data; dat_drv <= 1'b1; bcnt <= '0; st <= B_RD;
              end else begin
                st <= B_IDLE;
              end
            end
          end
          default: st <= B_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/vreg_access_router.sv
module vreg_access_router
  import vreg_pkg::*;
#(
  parameter logic [7:0] STAT_A  = 8'h00,
  parameter logic [7:0] STAT_B  = 8'h01,
  parameter logic [7:0] LUT_SUB = 8'hFF,
  parameter logic [7:0] CUR_SUB = 8'hFE,
  parameter int         NBANK   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_p,
  input  logic             wr_begin,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rd_next,
  input  logic             mem_pd,
  output logic [7:0]       reg_addr,
  output logic             reg_we,
  output logic [7:0]       reg_wdata,
  output logic [NBANK-1:0] lut_we,
  output logic [7:0]       lut_addr,
  output logic [7:0]       lut_wdata,
  output logic             cur_we,
  output logic [7:0]       cur_addr,
  output logic [7:0]       cur_wdata
);
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam logic [NBANK-1:0] FIRST = {{(NBANK-1){1'b0}}, 1'b1};

  wmode_t        mode;
  logic [7:0]    sub, lptr, cptr;
  logic [BW-1:0] bank;
  logic          inc_pend;

  assign reg_addr = sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= M_SUB; sub <= '0; lptr <= '0; cptr <= '0; bank <= '0;
      inc_pend <= 1'b0; reg_we <= 1'b0; reg_wdata <= '0;
      lut_we <= '0; lut_addr <= '0; lut_wdata <= '0;
      cur_we <= 1'b0; cur_addr <= '0; cur_wdata <= '0;
    end else begin
      reg_we   <= 1'b0;
      lut_we   <= '0;
      cur_we   <= 1'b0;
      inc_pend <= 1'b0;
      if (inc_pend) sub <= sub + 8'd1;
      if (start_p) bank <= '0;
      if (wr_begin) begin
        mode <= M_SUB;
      end else if (rd_next) begin
        sub <= sub + 8'd1;
      end else if (rx_valid) begin
        case (mode)
          M_SUB: begin
            sub <= rx_byte;
            if (rx_byte == LUT_SUB)      mode <= M_LIDX;
            else if (rx_byte == CUR_SUB) mode <= M_CIDX;
            else                         mode <= M_REG;
          end
          M_REG: begin
            reg_we    <= (sub != STAT_A) && (sub != STAT_B);
            reg_wdata <= rx_byte;
            inc_pend  <= 1'b1;
          end
          M_LIDX: begin
            lptr <= rx_byte; bank <= '0; mode <= M_LDAT;
          end
          M_LDAT: begin
            lut_we    <= mem_pd ? '0 : (FIRST << bank);
            lut_addr  <= lptr;
            lut_wdata <= rx_byte;
            if (bank == BW'(NBANK - 1)) begin
              bank <= '0; lptr <= lptr + 8'd1;
            end else begin
              bank <= bank + BW'(1);
            end
          end
          M_CIDX: begin
            cptr <= rx_byte; mode <= M_CDAT;
          end
          M_CDAT: begin
            cur_we    <= ~mem_pd;
            cur_addr  <= cptr;
            cur_wdata <= rx_byte;
            cptr      <= cptr + 8'd1;
          end
          default: mode <= M_SUB;
        endcase
      end
    end
  end
endmodule

// File: rtl/vreg_i2c_port.sv
module vreg_i2c_port #(
  parameter logic [6:0] DEV_ADDR    = 7'h44,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] STAT_A      = 8'h00,
  parameter logic [7:0] STAT_B      = 8'h01,
  parameter logic [7:0] LUT_SUB     = 8'hFF,
  parameter logic [7:0] CUR_SUB     = 8'hFE,
  parameter int         NBANK       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             mem_pd,
  output logic [7:0]       reg_addr,
  output logic             reg_we,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata,
  output logic [NBANK-1:0] lut_we,
  output logic [7:0]       lut_addr,
  output logic [7:0]       lut_wdata,
  output logic             cur_we,
  output logic [7:0]       cur_addr,
  output logic [7:0]       cur_wdata
);
  logic       sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic [7:0] rx_byte;
  logic       rx_valid, wr_begin, rd_next;

  vreg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p)
  );

  vreg_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .tx_data(reg_rdata), .sda_oe(sda_oe),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .wr_begin(wr_begin), .rd_next(rd_next)
  );

  vreg_access_router #(
    .STAT_A(STAT_A), .STAT_B(STAT_B), .LUT_SUB(LUT_SUB), .CUR_SUB(CUR_SUB), .NBANK(NBANK)
  ) u_route (
    .clk(clk), .rst(rst), .start_p(start_p), .wr_begin(wr_begin), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rd_next(rd_next), .mem_pd(mem_pd), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .lut_we(lut_we), .lut_addr(lut_addr),
    .lut_wdata(lut_wdata), .cur_we(cur_we), .cur_addr(cur_addr), .cur_wdata(cur_wdata)
  );
endmodule

// File: rtl/vreg_i2c_port_chk.sv
module vreg_i2c_port_chk #(
  parameter logic [7:0] STAT_A = 8'h00,
  parameter logic [7:0] STAT_B = 8'h01,
  parameter int         NBANK  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_pd,
  input logic             reg_we,
  input logic [7:0]       reg_addr,
  input logic [NBANK-1:0] lut_we,
  input logic             cur_we
);
  AST_STATUS_PROTECT: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (reg_addr != STAT_A && reg_addr != STAT_B)); // R4
  AST_REG_PULSE: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we); // R2
  AST_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lut_we)); // R5
  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
    (lut_we != '0) |-> (!cur_we && !reg_we)); // R5
  AST_PD_BLOCKS_MEM: assert property (@(posedge clk) disable iff (rst)
    (mem_pd && $past(mem_pd)) |-> (lut_we == '0 && !cur_we)); // R9
endmodule

bind vreg_i2c_port vreg_i2c_port_chk #(
  .STAT_A(STAT_A), .STAT_B(STAT_B), .NBANK(NBANK)
) u_chk (
  .clk(clk), .rst(rst), .mem_pd(mem_pd), .reg_we(reg_we), .reg_addr(reg_addr),
  .lut_we(lut_we), .cur_we(cur_we)
);

// File: tb/vreg_i2c_port_tb.sv
module vreg_i2c_port_tb;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, mem_pd = 1'b0;
  logic sda_oe, reg_we, cur_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata, lut_addr, lut_wdata, cur_addr, cur_wdata;
  logic [2:0] lut_we;
  logic sda_line;

  logic [7:0] regs [256];
  logic [7:0] lut_r [256];
  logic [7:0] lut_g [256];
  logic [7:0] lut_b [256];
  logic [7:0] curm  [256];
  int lut_cnt, cur_cnt, we_cnt;
  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = regs[reg_addr];

  vreg_i2c_port u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .mem_pd(mem_pd), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .lut_we(lut_we), .lut_addr(lut_addr), .lut_wdata(lut_wdata),
    .cur_we(cur_we), .cur_addr(cur_addr), .cur_wdata(cur_wdata)
  );

  // models of the storage behind the ports
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) begin
        regs[i] <= 8'(i) ^ 8'h3C;
        lut_r[i] <= 8'h00; lut_g[i] <= 8'h00; lut_b[i] <= 8'h00; curm[i] <= 8'h00;
      end
      lut_cnt <= 0; cur_cnt <= 0; we_cnt <= 0;
    end else begin
      if (reg_we) begin regs[reg_addr] <= reg_wdata; we_cnt <= we_cnt + 1; end
      if (lut_we != 3'b000) lut_cnt <= lut_cnt + 1;
      if (lut_we[0]) lut_r[lut_addr] <= lut_wdata;
      if (lut_we[1]) lut_g[lut_addr] <= lut_wdata;
      if (lut_we[2]) lut_b[lut_addr] <= lut_wdata;
      if (cur_we) begin curm[cur_addr] <= cur_wdata; cur_cnt <= cur_cnt + 1; end
    end
  end

  task automatic clkw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; clkw(Q); scl_m = 1'b1; clkw(Q);
    sda_m = 1'b0; clkw(Q); scl_m = 1'b0; clkw(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; clkw(Q); scl_m = 1'b1; clkw(Q);
    sda_m = 1'b1; clkw(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; clkw(Q); scl_m = 1'b1; clkw(2*Q); scl_m = 1'b0; clkw(Q);
    end
    sda_m = 1'b1; clkw(Q); scl_m = 1'b1; clkw(Q);
    ack = ~sda_line;
    clkw(Q); scl_m = 1'b0; clkw(Q);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clkw(Q); scl_m = 1'b1; clkw(Q); b[i] = sda_line; clkw(Q); scl_m = 1'b0;
    end
    clkw(Q); sda_m = nack; clkw(Q); scl_m = 1'b1; clkw(2*Q); scl_m = 1'b0;
    clkw(Q); sda_m = 1'b1;
  endtask

  task automatic send_acked(input string tag, input logic [7:0] b);
    logic a;
    send_byte(b, a);
    chk(tag, {31'd0, a}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R10 sda released", {31'd0, sda_oe}, 32'd0);
    chk("R10 no strobes", {28'd0, lut_we, cur_we}, 32'd0);
    chk("R10 no reg write", {31'd0, reg_we}, 32'd0);
  endtask

  task automatic t_address();
    logic a;
    bus_start(); send_byte(8'h8A, a);
    chk("R1 foreign address not acked", {31'd0, a}, 32'd0);
    send_byte(8'h20, a); send_byte(8'h55, a); bus_stop();
    chk("R1 foreign transfer no write", we_cnt, 0);
    chk("R1 foreign transfer reg intact", {24'd0, regs[8'h20]}, {24'd0, 8'h20 ^ 8'h3C});
  endtask

  task automatic t_reg_write();
    bus_start(); send_acked("R1 own address acked", 8'h88);
    send_acked("R2 sub ack", 8'h10);
    send_acked("R2 data ack", 8'h11); send_acked("R2 data ack", 8'h22);
    send_acked("R2 data ack", 8'h33); bus_stop();
    chk("R2 reg 0x10", {24'd0, regs[8'h10]}, 32'h11);
    chk("R2 reg 0x11", {24'd0, regs[8'h11]}, 32'h22);
    chk("R2 reg 0x12", {24'd0, regs[8'h12]}, 32'h33);
  endtask

  task automatic t_read();
    logic [7:0] d;
    bus_start(); send_acked("R3 addr", 8'h88); send_acked("R3 sub", 8'h10);
    bus_start(); send_acked("R3 read addr ack", 8'h89);
    recv_byte(1'b0, d); chk("R3 read byte 0", {24'd0, d}, 32'h11);
    recv_byte(1'b0, d); chk("R3 read byte 1", {24'd0, d}, 32'h22);
    recv_byte(1'b1, d); chk("R3 read byte 2", {24'd0, d}, 32'h33);
    bus_stop();
    chk("R3 sda released after nack", {31'd0, sda_oe}, 32'd0);
    bus_start(); send_acked("R3 read addr ack", 8'h89);
    recv_byte(1'b1, d); bus_stop();
    chk("R3 continues at next subaddress", {24'd0, d}, {24'd0, 8'h13 ^ 8'h3C});
  endtask

  task automatic t_status();
    logic [7:0] d;
    bus_start(); send_acked("R4 addr", 8'h88); send_acked("R4 sub", 8'h00);
    send_acked("R4 data ack", 8'hEE); send_acked("R4 data ack", 8'hEF);
    send_acked("R4 data ack", 8'h77); bus_stop();
    chk("R4 status 0 kept", {24'd0, regs[8'h00]}, 32'h3C);
    chk("R4 status 1 kept", {24'd0, regs[8'h01]}, 32'h3D);
    chk("R4 subaddress advanced past status", {24'd0, regs[8'h02]}, 32'h77);
    bus_start(); send_acked("R4 addr", 8'h88); send_acked("R4 sub", 8'h00);
    bus_start(); send_acked("R4 read addr", 8'h89);
    recv_byte(1'b1, d); bus_stop();
    chk("R4 status read back", {24'd0, d}, 32'h3C);
  endtask

  task automatic t_lut();
    int c0;
    c0 = lut_cnt;
    bus_start(); send_acked("R5 addr", 8'h88); send_acked("R5 sub", 8'hFF);
    send_acked("R5 index", 8'h20);
    send_acked("R5 red", 8'hA0); send_acked("R5 green", 8'hA1); send_acked("R5 blue", 8'hA2);
    send_acked("R6 red", 8'hB0); send_acked("R6 green", 8'hB1); send_acked("R6 blue", 8'hB2);
    bus_stop();
    chk("R5 entry 0x20", {8'd0, lut_r[8'h20], lut_g[8'h20], lut_b[8'h20]}, 32'h00A0A1A2);
    chk("R6 entry 0x21", {8'd0, lut_r[8'h21], lut_g[8'h21], lut_b[8'h21]}, 32'h00B0B1B2);
    chk("R5 strobe count", lut_cnt - c0, 6);
    chk("R5 no register write", {24'd0, regs[8'hFF]}, {24'd0, 8'hFF ^ 8'h3C});
  endtask

  task automatic t_lut_wrap();
    bus_start(); send_acked("R6 addr", 8'h88); send_acked("R6 sub", 8'hFF);
    send_acked("R6 index", 8'hFF);
    send_acked("R6 data", 8'hC0); send_acked("R6 data", 8'hC1); send_acked("R6 data", 8'hC2);
    send_acked("R6 data", 8'hD0); send_acked("R6 data", 8'hD1); send_acked("R6 data", 8'hD2);
    bus_stop();
    chk("R6 entry 0xFF", {8'd0, lut_r[8'hFF], lut_g[8'hFF], lut_b[8'hFF]}, 32'h00C0C1C2);
    chk("R6 wrapped entry 0x00", {8'd0, lut_r[8'h00], lut_g[8'h00], lut_b[8'h00]}, 32'h00D0D1D2);
  endtask

  task automatic t_phase();
    bus_start(); send_acked("R7 addr", 8'h88); send_acked("R7 sub", 8'hFF);
    send_acked("R7 index", 8'h30); send_acked("R7 red", 8'hE0); send_acked("R7 green", 8'hE1);
    bus_start(); send_acked("R7 addr", 8'h88); send_acked("R7 sub", 8'hFF);
    send_acked("R7 index", 8'h40);
    send_acked("R7 red", 8'hF0); send_acked("R7 green", 8'hF1); send_acked("R7 blue", 8'hF2);
    bus_stop();
    chk("R7 partial entry 0x30", {8'd0, lut_r[8'h30], lut_g[8'h30], lut_b[8'h30]}, 32'h00E0E100);
    chk("R7 entry 0x40 starts at red", {8'd0, lut_r[8'h40], lut_g[8'h40], lut_b[8'h40]}, 32'h00F0F1F2);
  endtask

  task automatic t_cursor();
    int c0;
    c0 = cur_cnt;
    bus_start(); send_acked("R8 addr", 8'h88); send_acked("R8 sub", 8'hFE);
    send_acked("R8 index", 8'hFE);
    send_acked("R8 data", 8'h61); send_acked("R8 data", 8'h62); send_acked("R8 data", 8'h63);
    bus_stop();
    chk("R8 cursor 0xFE", {24'd0, curm[8'hFE]}, 32'h61);
    chk("R8 cursor 0xFF", {24'd0, curm[8'hFF]}, 32'h62);
    chk("R8 cursor wrap 0x00", {24'd0, curm[8'h00]}, 32'h63);
    chk("R8 strobe count", cur_cnt - c0, 3);
  endtask

  task automatic t_powerdown();
    int l0, c0;
    mem_pd = 1'b1; clkw(4);
    l0 = lut_cnt; c0 = cur_cnt;
    bus_start(); send_acked("R9 addr", 8'h88); send_acked("R9 sub", 8'hFF);
    send_acked("R9 index", 8'h50);
    send_acked("R9 data ack", 8'h01); send_acked("R9 data ack", 8'h02);
    send_acked("R9 data ack", 8'h03);
    bus_start(); send_acked("R9 addr", 8'h88); send_acked("R9 sub", 8'hFE);
    send_acked("R9 index", 8'h50); send_acked("R9 data ack", 8'h04);
    bus_start(); send_acked("R9 addr", 8'h88); send_acked("R9 sub", 8'h40);
    send_acked("R9 data ack", 8'h99);
    bus_stop();
    chk("R9 no palette strobe", lut_cnt - l0, 0);
    chk("R9 no cursor strobe", cur_cnt - c0, 0);
    chk("R9 palette entry intact", {8'd0, lut_r[8'h50], lut_g[8'h50], lut_b[8'h50]}, 32'd0);
    chk("R9 register still written", {24'd0, regs[8'h40]}, 32'h99);
    mem_pd = 1'b0; clkw(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    clkw(5); rst = 1'b0; clkw(5);
    t_reset();
    t_address();
    t_reg_write();
    t_read();
    t_status();
    t_lut();
    t_lut_wrap();
    t_phase();
    t_cursor();
    t_powerdown();
    clkw(10);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule